// File: doc/BRIEF.md
# Dual Interval Timer with Timestamp

This peripheral sits on a simple 32-bit register bus. It holds a free-running 32-bit timestamp counter and two down-counting interval timers. Each interval timer has one combined control word, its reload register. The top bits of this word give the interval and the two bottom bits give the mode. As a result, a single write sets the period and the mode together and starts the count.

When an interval timer expires, it latches a pending flag. That flag drives the timer's interrupt line as a level. A timer in periodic mode reloads itself and keeps running. A timer in one-shot mode clears its own enable bit and stops at zero. The timestamp counter raises its own pending flag when it wraps. A shared status word gathers all the pending flags, and software clears them by writing ones to it. Software should program intervals between 0xF and 0xFFFFFFFE ticks.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, all pending flags, interrupt outputs, reload registers and down-counters are zero, and register reads return zero.
- R2: Register byte offsets: timestamp 0x00, timer 0 count 0x04, timer 0 reload 0x08, timer 1 count 0x0C, timer 1 reload 0x10, status 0x20. Read data appears on `bus_rdata` one clock after the address is presented and reflects the state at that edge.
- R3: Each clock, the timestamp counter increments by one. A write to offset 0x00 loads the written value at that edge.
- R4: When the timestamp counter steps from 0xFFFFFFFF to 0, status bit 2 and `irq_stamp` are set.
- R5: Reload register layout: bit 0 is the enable, bit 1 selects one-shot, and bits 31:2 hold the count, whose two low bits are forced to zero. The write edge loads that count into the down-counter. From then on, the count register reads the current down-count, which falls by one per clock while enabled.
- R6: In periodic mode (bit 0 = 1, bit 1 = 0) with count N, the pending flag is set N clocks after the reload write edge. It is set again every N clocks after that.
- R7: In one-shot mode (bit 0 = 1, bit 1 = 1), the timer expires once, N clocks after the write. It then clears its enable bit, keeps its mode and count bits, holds the down-counter at zero, and does not expire again.
- R8: With the enable bit clear, the down-counter holds the loaded count and never expires. Writing zero to the reload register stops the timer and clears the counter.
- R9: Status bit 0 is timer 0 pending, bit 1 is timer 1 pending, and bit 2 is timestamp pending. Writing a 1 to a bit clears that flag. Writing a 0 leaves it unchanged. A flag stays set until it is cleared.
- R10: `irq_tmr[i]` and `irq_stamp` follow the level of their pending flags and drop on the clock after the clearing write.
- R11: The two interval timers run independently. Activity on one never sets the flag of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W (6) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_tmr | output | NUM_CH (2) | Interval timer interrupt levels |
| irq_stamp | output | 1 | Timestamp wrap interrupt level |

## Verification
Every result lands on a fixed edge, and the bench keeps its own cycle count to sample on that edge.

- A register write takes effect at its own edge. A read issued right after it returns the post-write value one edge later.
- A read issued k edges after a load returns the timestamp plus k, or the count minus k.
- A timer interrupt is due exactly N edges after its reload write edge, and 2N edges after it for the second period.
- The timestamp flag is due 16 edges after a load of 0xFFFFFFF0.
- A clear takes effect on the edge of the status write.

Between events, the bench samples the interrupt lines at every falling edge. This catches early or extra expiries.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  // reload word mode bits
  localparam int EN_BIT = 0;
  localparam int OS_BIT = 1;
  localparam int MODE_W = 2;

  // register byte offsets
  localparam int TS_OFS     = 0;
  localparam int STAT_OFS   = 32;
  localparam int CH_STRIDE  = 8;
  localparam int CH_VAL_OFS = 4;
  localparam int CH_RLD_OFS = 8;

  function automatic int val_ofs(input int ch);
    return CH_VAL_OFS + CH_STRIDE * ch;
  endfunction

  function automatic int rld_ofs(input int ch);
    return CH_RLD_OFS + CH_STRIDE * ch;
  endfunction
endpackage

// File: rtl/itmr_stamp.sv
module itmr_stamp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] wdata,
  input  logic         clr_pend,
  output logic [W-1:0] ts_o,
  output logic         pend_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] ts_q;
  logic         pend_q;
  logic         wrap;

  assign wrap = !load && (&ts_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q <= '0;
    end else if (load) begin
      ts_q <= wdata;
    end else begin
      ts_q <= ts_q + ONE;
    end
  end

  // a new wrap wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (wrap) begin
      pend_q <= 1'b1;
    end else if (clr_pend) begin
      pend_q <= 1'b0;
    end
  end

  assign ts_o   = ts_q;
  assign pend_o = pend_q;

  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    !load |=> ts_q == $past(ts_q) + ONE); // R3
  AST_TS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && ts_q == '1) |=> (pend_q && ts_q == '0)); // R4
  AST_TS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_pend) |=> pend_q); // R9
endmodule

// File: rtl/itmr_chan.sv
module itmr_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload_wr,
  input  logic [W-1:0] wdata,
  input  logic         clr_pend,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] reload_o,
  output logic         pend_o
);
  import itmr_pkg::*;

  localparam logic [W-1:0] ONE      = W'(1);
  localparam logic [W-1:0] CNT_MASK = ~W'((1 << MODE_W) - 1);

  logic [W-1:0] rld_q;
  logic [W-1:0] cnt_q;
  logic         pend_q;
  logic         run;
  logic         oneshot;
  logic         at_end;
  logic         expire;

  assign run     = rld_q[EN_BIT];
  assign oneshot = rld_q[OS_BIT];
  // expiring on the step into zero gives a period of exactly N clocks
  assign at_end  = (cnt_q <= ONE);
  assign expire  = run && at_end && !reload_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q <= '0;
      cnt_q <= '0;
    end else if (reload_wr) begin
      rld_q <= wdata;
      cnt_q <= wdata & CNT_MASK;
    end else if (run) begin
      if (at_end) begin
        if (oneshot) begin
          rld_q[EN_BIT] <= 1'b0;
          cnt_q         <= '0;
        end else begin
          cnt_q <= rld_q & CNT_MASK;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (expire) begin
      pend_q <= 1'b1;
    end else if (clr_pend) begin
      pend_q <= 1'b0;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = rld_q;
  assign pend_o   = pend_q;

  AST_CNT_DECR: assert property (@(posedge clk) disable iff (rst)
    (!reload_wr && rld_q[EN_BIT] && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE); // R5
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!reload_wr && rld_q[EN_BIT] && !rld_q[OS_BIT] && cnt_q <= ONE)
      |=> (pend_q && cnt_q == ($past(rld_q) & CNT_MASK))); // R6
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (!reload_wr && rld_q[EN_BIT] && rld_q[OS_BIT] && cnt_q <= ONE)
      |=> (pend_q && !rld_q[EN_BIT] && cnt_q == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!reload_wr && !rld_q[EN_BIT]) |=> $stable(cnt_q)); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_pend) |=> pend_q); // R9
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_tmr,
  output logic              irq_stamp
);
  import itmr_pkg::*;

  localparam int STAT_W = NUM_CH + 1;
  localparam logic [ADDR_W-1:0] TS_A   = ADDR_W'(TS_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  logic [DATA_W-1:0] cnt_v [NUM_CH];
  logic [DATA_W-1:0] rld_v [NUM_CH];
  logic [NUM_CH-1:0] pend_v;
  logic [DATA_W-1:0] ts;
  logic              pend_ts;
  logic              stat_wr;
  logic [STAT_W-1:0] clr_bits;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;

  assign stat_wr  = bus_wr && (bus_addr == STAT_A);
  assign clr_bits = stat_wr ? bus_wdata[STAT_W-1:0] : '0;

  itmr_stamp #(.W(DATA_W)) u_stamp (
    .clk      (clk),
    .rst      (rst),
    .load     (bus_wr && (bus_addr == TS_A)),
    .wdata    (bus_wdata),
    .clr_pend (clr_bits[NUM_CH]),
    .ts_o     (ts),
    .pend_o   (pend_ts)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    localparam logic [ADDR_W-1:0] RLD_A = ADDR_W'(rld_ofs(g));
    logic pend_w;

    itmr_chan #(.W(DATA_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .reload_wr (bus_wr && (bus_addr == RLD_A)),
      .wdata     (bus_wdata),
      .clr_pend  (clr_bits[g]),
      .cnt_o     (cnt_v[g]),
      .reload_o  (rld_v[g]),
      .pend_o    (pend_w)
    );

    assign pend_v[g] = pend_w;
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == TS_A) begin
      rd_next = ts;
    end
    if (bus_addr == STAT_A) begin
      rd_next = DATA_W'({pend_ts, pend_v});
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(val_ofs(i))) begin
        rd_next = cnt_v[i];
      end
      if (bus_addr == ADDR_W'(rld_ofs(i))) begin
        rd_next = rld_v[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_next;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_tmr   = pend_v;
  assign irq_stamp = pend_ts;

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && bus_wdata[0] && !(rld_v[0][EN_BIT] && cnt_v[0] <= DATA_W'(1)))
      |=> !irq_tmr[0]); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq_tmr == '0 && !irq_stamp && bus_rdata == '0)); // R1
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
  localparam int W   = 32;
  localparam int AW  = 6;
  localparam int NCH = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [NCH-1:0] irq_tmr;
  logic          irq_stamp;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_interval_timer #(.DATA_W(W), .ADDR_W(AW), .NUM_CH(NCH)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_tmr   (irq_tmr),
    .irq_stamp (irq_stamp)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic run_timer(input int ch, input int n, input bit os);
    int rl = 8 + 8 * ch;
    int vl = 4 + 8 * ch;
    int oc = 1 - ch;
    int c0;
    bit bad;
    logic [W-1:0] d;
    string tag = os ? "R7" : "R6";
    wr(rl, W'(n) | (os ? W'(3) : W'(1)));
    c0 = cyc;
    rd(vl, d); check(d == W'(n), "R5 count after load", d, W'(n));
    rd(vl, d); check(d == W'(n - 1), "R5 count after one clock", d, W'(n - 1));
    bad = 0;
    while (cyc - c0 < n) begin
      if (irq_tmr != '0) bad = 1;
      step();
    end
    check(!bad, {tag, " early expiry"}, W'(bad), 0);
    check(irq_tmr[ch] == 1'b1, {tag, " first expiry at N"}, W'(irq_tmr[ch]), 1);
    check(irq_tmr[oc] == 1'b0, "R11 other timer quiet", W'(irq_tmr[oc]), 0);
    rd(32, d); check(d[2:0] == 3'(1 << ch), "R9 status bit", d, W'(1 << ch));
    wr(32, 0);
    rd(32, d); check(d[ch] == 1'b1, "R9 zero write keeps flag", d, W'(1 << ch));
    wr(32, W'(1 << ch));
    check(irq_tmr[ch] == 1'b0, "R10 irq drops after clear", W'(irq_tmr[ch]), 0);
    bad = 0;
    if (!os) begin
      while (cyc - c0 < 2 * n) begin
        if (irq_tmr[ch]) bad = 1;
        step();
      end
      check(!bad && irq_tmr[ch], "R6 second expiry at 2N", W'(irq_tmr[ch]), 1);
      wr(32, W'(1 << ch));
      wr(rl, 0);
      rd(vl, d); check(d == 0, "R8 zero write clears counter", d, 0);
    end else begin
      while (cyc - c0 < 3 * n) begin
        if (irq_tmr[ch]) bad = 1;
        step();
      end
      check(!bad, "R7 no second expiry", W'(bad), 0);
      rd(rl, d); check(d == W'(n | 2), "R7 enable bit self-cleared", d, W'(n | 2));
      rd(vl, d); check(d == 0, "R7 counter held at zero", d, 0);
      wr(rl, 0);
    end
  endtask

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] v;
    int c0;
    int c;
    bit bad;

    repeat (4) step();
    check(irq_tmr == '0 && irq_stamp == 1'b0, "R1 irqs in reset", W'({irq_stamp, irq_tmr}), 0);
    rst = 1'b0;
    rd(32, d); check(d == 0, "R1 status after reset", d, 0);
    rd(8, d);  check(d == 0, "R1 reload 0 after reset", d, 0);
    rd(16, d); check(d == 0, "R1 reload 1 after reset", d, 0);
    rd(4, d);  check(d == 0, "R1 count 0 after reset", d, 0);
    rd(12, d); check(d == 0, "R1 count 1 after reset", d, 0);

    // R2 map decode: reload 0 written, reload 1 untouched
    wr(8, 32'h0000_0100);
    rd(8, d);  check(d == 32'h100, "R2 reload 0 readback", d, 32'h100);
    rd(16, d); check(d == 0, "R2 reload 1 untouched", d, 0);
    rd(4, d);  check(d == 32'h100, "R2 count 0 readback", d, 32'h100);
    wr(8, 0);

    // R3 timestamp load and count
    for (int i = 0; i < 8; i++) begin
      v = 32'h1357_9BDF * i + 32'h11;
      wr(0, v);
      c0 = cyc;
      rd(0, d); check(d == v, "R3 load value", d, v);
      repeat (i + 3) step();
      c = cyc;
      rd(0, d); check(d == v + W'(c - c0), "R3 count up", d, v + W'(c - c0));
    end

    // R4 wrap
    v = 32'hFFFF_FFF0;
    wr(0, v);
    c0 = cyc;
    bad = 0;
    while (cyc - c0 < 16) begin
      if (irq_stamp) bad = 1;
      step();
    end
    check(!bad && irq_stamp, "R4 wrap flag at 16", W'(irq_stamp), 1);
    rd(32, d); check(d[2:0] == 3'b100, "R4 status bit 2", d, 4);
    wr(32, 4);
    check(irq_stamp == 1'b0, "R10 stamp irq cleared", W'(irq_stamp), 0);

    // R5 R6 R7 sweep
    for (int ch = 0; ch < 2; ch++)
      for (int os = 0; os < 2; os++)
        for (int n = 16; n <= 64; n += 4)
          run_timer(ch, n, os[0]);

    // R8 disabled timer holds
    wr(8, 20);
    bad = 0;
    repeat (40) begin
      if (irq_tmr[0]) bad = 1;
      step();
    end
    check(!bad, "R8 disabled no expiry", W'(bad), 0);
    rd(4, d); check(d == 20, "R8 count held", d, 20);
    wr(8, 21);
    repeat (3) step();
    wr(8, 0);
    rd(4, d); check(d == 0, "R8 stop clears count", d, 0);
    bad = 0;
    repeat (60) begin
      if (irq_tmr[0]) bad = 1;
      step();
    end
    check(!bad, "R8 stopped no expiry", W'(bad), 0);

    // R11 both timers together
    wr(8, 16 | 1);
    c0 = cyc;
    wr(16, 24 | 1);
    bad = 0;
    while (cyc - c0 < 30) begin
      if (irq_tmr[0] != (cyc - c0 >= 16)) bad = 1;
      if (irq_tmr[1] != (cyc - c0 >= 25)) bad = 1;
      step();
    end
    check(!bad, "R11 independent expiries", W'(bad), 0);
    wr(32, 3);
    wr(8, 0);
    wr(16, 0);
    check(irq_tmr == '0, "R10 both cleared", W'(irq_tmr), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule